// File: doc/BRIEF.md
# Auto-Reload PWM Channel with Selectable 9/10/11-Bit Period

This block is a single pulse-width channel driven by a private 16-bit free-running timebase. Only the low N bits of the timebase set the period, and N is picked from 9, 10 or 11 through a two-bit length code. The output rises when the masked count reaches the compare value. It falls when the count wraps out of bit N-1, so the output is high for 2^N minus the compare value clocks of every period.

Software reaches the channel through a byte-wide register bus with an 8-location map. Two data addresses, low byte and high byte, lead either to the live compare register or to a shadow reload register, depending on a select bit. The shadow value is moved into the compare register at every wrap, so a duty change always takes effect at a period boundary. A write to the low data byte turns the comparator off and a write to the high byte turns it back on, so a two-byte update is made low byte first. Sticky flags report each wrap and, when enabled, each rising edge of the output.

Top module: `pwm_ar_chan`

## Requirements
- R1: Length code 01, 10 and 11 in CFG[1:0] (address 1) select N = 9, 10 and 11. After the timebase is cleared and started, the wrap flag CFG[3] is still 0 after 2^N-1 counting clocks and reads 1 after the 2^N-th.
- R2: With the channel active, the output is high exactly while the low N bits of the count are at or above the compare value. It is therefore high for 2^N - compare clocks in each period: all 2^N for compare 0 and one clock for compare 2^N-1.
- R3: At each wrap the reload register is copied into the compare register. A new reload value changes the output only from the next period, and afterwards the compare register reads back that value.
- R4: When CFG[2] is 1, data addresses 3 (bits 7:0) and 4 (bits 10:8 in bits 2:0) read and write the reload register. When CFG[2] is 0, they read and write the compare register. Values are right-justified.
- R5: A write to address 3 clears the comparator enable MODE[1] (address 2), and a write to address 4 sets it.
- R6: The output stays low while MODE[0] (PWM mode) is 0, MODE[1] is 0, or the length code is 00. With length code 00 no wrap occurs and CFG[3] is never set.
- R7: If MODE[2] is 1, the match flag MODE[3] is set on every compare match that raises the output. When MODE[2] is 0 or the channel is inactive it is not set. Writing MODE with bit 3 = 1 leaves the flag unchanged, and writing it with bit 3 = 0 clears it.
- R8: The wrap flag CFG[3] is sticky. Writing CFG with bit 3 = 1 leaves it unchanged and writing bit 3 = 0 clears it. A wrap in the same clock as a clearing write leaves it set.
- R9: CTRL[0] (address 0) runs the timebase. While it is 0 the count and output hold. Writing CTRL with bit 1 = 1 zeroes the count on that clock. The count reads back at addresses 5 (low byte) and 6 (high byte).
- R10: Compare and reload bits at or above bit N have no effect on the output.
- R11: After reset every register reads 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the timebase count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe, one write per clock |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| pwm_o | output | 1 | Channel output |

## Verification
The assertions assume that each bus write lasts exactly one clock with stable address and data, and that the reset is asynchronous and taken once at start-up. They also assume that the compare register is loaded only by a write or by a wrap, so that after a wrap it equals the reload value of the previous clock. The stimulus drives every write for one clock from the falling edge and always writes the low data byte before the high one. Before each configuration it stops and clears the timebase, so that all period measurements start from count zero and the clock of every wrap is known in advance.

// File: rtl/pwm_ar_pkg.sv
`timescale 1ns/1ps
package pwm_ar_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_CFG  = 3'd1,
    A_MODE = 3'd2,
    A_DLO  = 3'd3,
    A_DHI  = 3'd4,
    A_TLO  = 3'd5,
    A_THI  = 3'd6
  } addr_e;

  // period width selected by the length code (00 is not a valid setting)
  function automatic int len_width(logic [1:0] code);
    return 8 + int'(code);
  endfunction
endpackage

// File: rtl/pwm_ar_timebase.sv
`timescale 1ns/1ps
module pwm_ar_timebase import pwm_ar_pkg::*; #(
  parameter int unsigned TB_W = 16,
  parameter int unsigned CW   = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [1:0]      len_i,
  output logic [TB_W-1:0] cnt_o,
  output logic [CW-1:0]   mask_o,
  output logic [CW-1:0]   nxt_o,
  output logic            ovf_o
);
  logic [TB_W-1:0] cnt_q;
  logic [CW-1:0]   low;
  logic            len_ok;

  assign low    = cnt_q[CW-1:0];
  assign len_ok = (len_i != 2'b00);

  always_comb begin
    for (int i = 0; i < int'(CW); i++) mask_o[i] = len_ok && (i < len_width(len_i));
  end

  assign nxt_o = (low + CW'(1)) & mask_o;
  assign ovf_o = run_i && !clr_i && len_ok && ((low & mask_o) == mask_o);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + TB_W'(1);
  end
endmodule

// File: rtl/pwm_ar_regs.sv
`timescale 1ns/1ps
module pwm_ar_regs import pwm_ar_pkg::*; #(
  parameter int unsigned TB_W = 16,
  parameter int unsigned CW   = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      addr_i,
  input  logic            we_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  input  logic [TB_W-1:0] cnt_i,
  input  logic            ovf_i,
  input  logic            match_i,
  output logic            run_o,
  output logic            clr_o,
  output logic [1:0]      len_o,
  output logic            active_o,
  output logic            mf_en_o,
  output logic            mf_flag_o,
  output logic            ovf_flag_o,
  output logic [CW-1:0]   cmp_o,
  output logic [CW-1:0]   rld_o
);
  localparam int unsigned HI_W = CW - 8;

  logic          run_q, arsel_q, ovf_flag_q, pwm_en_q, cmp_en_q, mf_en_q, mf_flag_q;
  logic [1:0]    len_q;
  logic [CW-1:0] cmp_q, rld_q, sel;
  logic          wr_ctrl, wr_cfg, wr_mode, wr_lo, wr_hi;

  assign wr_ctrl = we_i && (addr_e'(addr_i) == A_CTRL);
  assign wr_cfg  = we_i && (addr_e'(addr_i) == A_CFG);
  assign wr_mode = we_i && (addr_e'(addr_i) == A_MODE);
  assign wr_lo   = we_i && (addr_e'(addr_i) == A_DLO);
  assign wr_hi   = we_i && (addr_e'(addr_i) == A_DHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      len_q      <= 2'b00;
      arsel_q    <= 1'b0;
      ovf_flag_q <= 1'b0;
      pwm_en_q   <= 1'b0;
      cmp_en_q   <= 1'b0;
      mf_en_q    <= 1'b0;
      mf_flag_q  <= 1'b0;
      cmp_q      <= '0;
      rld_q      <= '0;
    end else begin
      if (wr_ctrl) run_q <= wdata_i[0];
      if (wr_cfg) begin
        len_q   <= wdata_i[1:0];
        arsel_q <= wdata_i[2];
      end
      // event set wins over a clearing write
      if (ovf_i)                      ovf_flag_q <= 1'b1;
      else if (wr_cfg && !wdata_i[3]) ovf_flag_q <= 1'b0;
      if (wr_mode) begin
        pwm_en_q <= wdata_i[0];
        mf_en_q  <= wdata_i[2];
      end
      if (wr_mode)    cmp_en_q <= wdata_i[1];
      else if (wr_lo) cmp_en_q <= 1'b0;
      else if (wr_hi) cmp_en_q <= 1'b1;
      if (match_i && mf_en_q)          mf_flag_q <= 1'b1;
      else if (wr_mode && !wdata_i[3]) mf_flag_q <= 1'b0;
      if (wr_lo && arsel_q) rld_q[7:0]    <= wdata_i;
      if (wr_hi && arsel_q) rld_q[CW-1:8] <= wdata_i[HI_W-1:0];
      if (ovf_i) cmp_q <= rld_q;
      else begin
        if (wr_lo && !arsel_q) cmp_q[7:0]    <= wdata_i;
        if (wr_hi && !arsel_q) cmp_q[CW-1:8] <= wdata_i[HI_W-1:0];
      end
    end
  end

  assign sel = arsel_q ? rld_q : cmp_q;

  always_comb begin
    case (addr_e'(addr_i))
      A_CTRL:  rdata_o = {7'd0, run_q};
      A_CFG:   rdata_o = {4'd0, ovf_flag_q, arsel_q, len_q};
      A_MODE:  rdata_o = {4'd0, mf_flag_q, mf_en_q, cmp_en_q, pwm_en_q};
      A_DLO:   rdata_o = sel[7:0];
      A_DHI:   rdata_o = 8'(sel >> 8);
      A_TLO:   rdata_o = cnt_i[7:0];
      A_THI:   rdata_o = 8'(cnt_i >> 8);
      default: rdata_o = 8'd0;
    endcase
  end

  assign run_o      = run_q;
  assign clr_o      = wr_ctrl && wdata_i[1];
  assign len_o      = len_q;
  assign active_o   = pwm_en_q && cmp_en_q && (len_q != 2'b00);
  assign mf_en_o    = mf_en_q;
  assign mf_flag_o  = mf_flag_q;
  assign ovf_flag_o = ovf_flag_q;
  assign cmp_o      = cmp_q;
  assign rld_o      = rld_q;
endmodule

// File: rtl/pwm_ar_out.sv
`timescale 1ns/1ps
module pwm_ar_out #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          step_i,
  input  logic          clr_i,
  input  logic          ovf_i,
  input  logic [CW-1:0] nxt_i,
  input  logic [CW-1:0] mask_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [CW-1:0] rld_i,
  output logic          pwm_o,
  output logic          match_o
);
  logic [CW-1:0] tgt;
  logic          pwm_q;

  // compare against the value that will be live when the next count is shown
  assign tgt     = (ovf_i ? rld_i : cmp_i) & mask_i;
  assign match_o = active_i && step_i && (nxt_i == tgt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pwm_q <= 1'b0;
    else if (clr_i)     pwm_q <= active_i && ((cmp_i & mask_i) == '0);
    else if (!active_i) pwm_q <= 1'b0;
    else if (match_o)   pwm_q <= 1'b1;
    else if (ovf_i)     pwm_q <= 1'b0;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_ar_chan.sv
`timescale 1ns/1ps
module pwm_ar_chan #(
  parameter int unsigned TB_W = 16,
  parameter int unsigned CW   = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] bus_addr_i,
  input  logic       bus_we_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       pwm_o
);
  logic [TB_W-1:0] cnt;
  logic [CW-1:0]   mask, nxt, cmp_q, rld_q;
  logic [1:0]      len;
  logic            run, tb_clr, ovf_evt, match_evt, active, mf_en, mf_flag, ovf_flag;

  pwm_ar_regs #(.TB_W(TB_W), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .cnt_i      (cnt),
    .ovf_i      (ovf_evt),
    .match_i    (match_evt),
    .run_o      (run),
    .clr_o      (tb_clr),
    .len_o      (len),
    .active_o   (active),
    .mf_en_o    (mf_en),
    .mf_flag_o  (mf_flag),
    .ovf_flag_o (ovf_flag),
    .cmp_o      (cmp_q),
    .rld_o      (rld_q)
  );

  pwm_ar_timebase #(.TB_W(TB_W), .CW(CW)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (tb_clr),
    .len_i  (len),
    .cnt_o  (cnt),
    .mask_o (mask),
    .nxt_o  (nxt),
    .ovf_o  (ovf_evt)
  );

  pwm_ar_out #(.CW(CW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .step_i   (run && !tb_clr),
    .clr_i    (tb_clr),
    .ovf_i    (ovf_evt),
    .nxt_i    (nxt),
    .mask_i   (mask),
    .cmp_i    (cmp_q),
    .rld_i    (rld_q),
    .pwm_o    (pwm_o),
    .match_o  (match_evt)
  );
endmodule

// File: rtl/pwm_ar_chan_chk.sv
`timescale 1ns/1ps
module pwm_ar_chan_chk #(
  parameter int unsigned TB_W = 16,
  parameter int unsigned CW   = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pwm_i,
  input logic            active_i,
  input logic            run_i,
  input logic            clr_i,
  input logic            ovf_i,
  input logic            match_i,
  input logic            mf_en_i,
  input logic            mf_flag_i,
  input logic            ovf_flag_i,
  input logic [TB_W-1:0] cnt_i,
  input logic [CW-1:0]   cmp_i,
  input logic [CW-1:0]   rld_i
);
  p_inactive_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !pwm_i);

  p_fall_on_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !match_i && !clr_i) |=> !pwm_i);

  p_rise_on_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> pwm_i);

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (cmp_i == $past(rld_i)));

  p_wrap_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_flag_i);

  p_match_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mf_en_i) |=> mf_flag_i);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_i));

  p_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |=> (cnt_i == $past(cnt_i) + 1'b1));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_i == '0));
endmodule

bind pwm_ar_chan pwm_ar_chan_chk #(.TB_W(TB_W), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwm_i      (pwm_o),
  .active_i   (active),
  .run_i      (run),
  .clr_i      (tb_clr),
  .ovf_i      (ovf_evt),
  .match_i    (match_evt),
  .mf_en_i    (mf_en),
  .mf_flag_i  (mf_flag),
  .ovf_flag_i (ovf_flag),
  .cnt_i      (cnt),
  .cmp_i      (cmp_q),
  .rld_i      (rld_q)
);

// File: tb/tb_pwm_ar_chan.sv
`timescale 1ns/1ps
module tb_pwm_ar_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wd = 8'd0;
  logic [7:0] bus_rd;
  logic       pwm;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  pwm_ar_chan dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (bus_addr),
    .bus_we_i    (bus_we),
    .bus_wdata_i (bus_wd),
    .bus_rdata_o (bus_rd),
    .pwm_o       (pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input int d);
    bus_addr = a;
    bus_wd   = 8'(d);
    bus_we   = 1'b1;
    @(negedge clk);
    bus_we   = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rd;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sample per count value k = 0..n-1, starting at the current falling edge
  task automatic measure(input int n, input int c, output int hi, output int mis);
    hi  = 0;
    mis = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm === 1'b1) hi++;
      if (pwm !== (k >= c)) mis++;
      @(negedge clk);
    end
  endtask

  // stop and clear the timebase, then load reload and compare values
  task automatic setup(input int len, input int cmpv, input int rldv, input int mode);
    wr(3'd0, 2);
    wr(3'd1, 4 | len);
    wr(3'd3, rldv & 255);
    wr(3'd4, rldv >> 8);
    wr(3'd1, len);
    wr(3'd3, cmpv & 255);
    wr(3'd4, cmpv >> 8);
    wr(3'd2, mode);
  endtask

  initial begin
    #(20 * 180000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    int hi, mis, n, c;
    int cl[5];

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk($sformatf("R11 reg %0d after reset", a), d, 0);
    end
    chk("R11 output low after reset", pwm, 0);

    // R1 R2 sweep over every length and a spread of compare values
    for (int l = 1; l <= 3; l++) begin
      n = 1 << (8 + l);
      cl[0] = 0; cl[1] = 1; cl[2] = n / 3; cl[3] = n / 2; cl[4] = n - 1;
      for (int j = 0; j < 5; j++) begin
        c = cl[j];
        setup(l, c, c, 8'h07);
        wr(3'd0, 3);
        idle(n - 1);
        rd(3'd1, d);
        chk($sformatf("R1 wrap flag before wrap N=%0d", 8 + l), d[3], 0);
        idle(1);
        rd(3'd1, d);
        chk($sformatf("R1 wrap flag after 2^N clocks N=%0d", 8 + l), d[3], 1);
        for (int p = 0; p < 2; p++) begin
          measure(n, c, hi, mis);
          chk($sformatf("R2 high time N=%0d cmp=%0d", 8 + l, c), hi, n - c);
          chk($sformatf("R2 shape mismatches N=%0d cmp=%0d", 8 + l, c), mis, 0);
        end
        rd(3'd2, d);
        chk($sformatf("R7 match flag set N=%0d cmp=%0d", 8 + l, c), d[3], 1);
      end
    end

    // R10 upper compare bits ignored
    setup(1, 12'h740, 12'h740, 8'h07);
    wr(3'd0, 3);
    measure(512, 12'h740 & 511, hi, mis);
    chk("R10 high time with bits above N", hi, 512 - (12'h740 & 511));
    chk("R10 shape mismatches", mis, 0);

    // R3 R4 shadow reload
    setup(1, 200, 200, 8'h07);
    wr(3'd0, 3);
    wr(3'd1, 8'h05);
    wr(3'd3, 64);
    wr(3'd4, 0);
    rd(3'd3, d);
    chk("R4 select=1 reads reload low byte", d, 64);
    wr(3'd1, 8'h01);
    rd(3'd3, d);
    rd(3'd4, d2);
    chk("R4 select=0 reads compare low byte", d, 200);
    chk("R4 select=0 reads compare high byte", d2, 0);
    wr(3'd0, 3);
    measure(512, 200, hi, mis);
    chk("R3 old duty until wrap", hi, 312);
    chk("R3 old duty shape", mis, 0);
    measure(512, 64, hi, mis);
    chk("R3 new duty after wrap", hi, 448);
    chk("R3 new duty shape", mis, 0);
    rd(3'd3, d);
    chk("R3 compare holds reload value", d, 64);

    // R4 high byte right-justified
    wr(3'd1, 8'h06);
    wr(3'd3, 8'h34);
    wr(3'd4, 8'h05);
    rd(3'd4, d);
    chk("R4 reload high byte readback", d, 5);
    rd(3'd3, d);
    chk("R4 reload low byte readback", d, 8'h34);

    // R5 byte writes toggle the comparator enable
    setup(1, 100, 100, 8'h07);
    wr(3'd0, 3);
    wr(3'd3, 100);
    rd(3'd2, d);
    chk("R5 low byte write clears enable", d[1], 0);
    wr(3'd0, 3);
    measure(512, 1 << 30, hi, mis);
    chk("R5 R6 output low with enable cleared", hi, 0);
    wr(3'd4, 0);
    rd(3'd2, d);
    chk("R5 high byte write sets enable", d[1], 1);
    wr(3'd0, 3);
    measure(512, 100, hi, mis);
    chk("R5 duty back after high byte", hi, 412);

    // R6 PWM mode bit off
    setup(1, 100, 100, 8'h06);
    wr(3'd0, 3);
    measure(512, 1 << 30, hi, mis);
    chk("R6 output low with mode bit 0", hi, 0);
    rd(3'd2, d);
    chk("R7 no match flag while inactive", d[3], 0);

    // R6 length code 00
    setup(0, 100, 100, 8'h07);
    wr(3'd0, 3);
    measure(600, 1 << 30, hi, mis);
    chk("R6 output low with length 00", hi, 0);
    rd(3'd1, d);
    chk("R6 no wrap with length 00", d[3], 0);

    // R7 match flag disabled, then set/keep/clear
    setup(1, 100, 100, 8'h03);
    wr(3'd0, 3);
    measure(512, 100, hi, mis);
    chk("R7 duty with flag disabled", hi, 412);
    rd(3'd2, d);
    chk("R7 flag stays 0 when disabled", d[3], 0);
    setup(3, 1000, 1000, 8'h07);
    wr(3'd0, 3);
    idle(1100);
    rd(3'd2, d);
    chk("R7 flag set after match", d[3], 1);
    wr(3'd2, 8'h0F);
    rd(3'd2, d);
    chk("R7 write 1 keeps flag", d[3], 1);
    wr(3'd2, 8'h07);
    rd(3'd2, d);
    chk("R7 write 0 clears flag", d[3], 0);

    // R8 wrap flag: clear colliding with wrap
    setup(1, 100, 100, 8'h07);
    wr(3'd0, 3);
    wr(3'd1, 8'h09);
    idle(510);
    rd(3'd1, d);
    chk("R8 flag clear before wrap", d[3], 0);
    wr(3'd1, 8'h01);
    rd(3'd1, d);
    chk("R8 set wins over same-cycle clear", d[3], 1);
    wr(3'd1, 8'h09);
    rd(3'd1, d);
    chk("R8 write 1 keeps flag", d[3], 1);
    wr(3'd1, 8'h01);
    rd(3'd1, d);
    chk("R8 write 0 clears flag", d[3], 0);

    // R9 run enable, clear and readback
    setup(1, 100, 100, 8'h07);
    wr(3'd0, 3);
    idle(300);
    wr(3'd0, 0);
    rd(3'd5, d);
    rd(3'd6, d2);
    idle(50);
    chk("R9 output high at count 301", pwm, 1);
    begin
      logic [7:0] e, e2;
      rd(3'd5, e);
      rd(3'd6, e2);
      chk("R9 count holds while stopped", {e2, e}, {d2, d});
      chk("R9 count value when stopped", {d2, d}, 301);
    end
    chk("R9 output holds while stopped", pwm, 1);
    wr(3'd0, 2);
    rd(3'd5, d);
    rd(3'd6, d2);
    chk("R9 clear zeroes count", {d2, d}, 0);
    wr(3'd0, 1);
    idle(5);
    rd(3'd5, d);
    chk("R9 count advances after run", d, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule